// File: doc/BRIEF.md
# Clock Source Lock and Slip Tracker

This block watches eleven external sample-clock sources and condenses them into two status words. The extended status word shows, for every source, a live lock flag and a sticky slip flag. The current-source status word shows whether the selected source is locked, together with the nominal rate code. Two single-cycle event pulses go to the notification logic. The first fires on any change of a lock flag. The second fires only when the lock of the currently selected source changes.

Slip flags record that a source had an error. They remain set until software reads the extended status word with a single-quadlet read, which the bus decoder signals with a one-cycle strobe. Block reads of the same word do not assert that strobe, so they leave the flags alone. Slip flags never raise an event.

None of the pins carries a data stream. Every input is a level or a single-cycle strobe, and every output is a registered status level or pulse. For that reason the block has no valid/ready handshake and applies no back-pressure.

Top module: `clk_lock_slip_tracker`

## Requirements
- R1: Extended status bit i (i = 0..10) equals lock input i from the previous cycle. The source order is AES1, AES2, AES3, AES4, ADAT, TDIF, ARX1, ARX2, ARX3, ARX4, word clock. Bits 15:11 read as zero.
- R2: `lock_evt` is high for exactly the cycle in which any bit 10:0 of the extended word differs from its value one cycle earlier. A lock flag that rises from its reset value of zero counts as a change.
- R3: A slip pulse on source i sets extended status bit 16+i in the next cycle. The bit then stays set until it is cleared. Bits 31:27 read as zero.
- R4: The cycle in which `rd_quad` is high still shows the slip bits. In the following cycle, every slip bit that was not re-pulsed during the strobe cycle reads zero.
- R5: A slip pulse that coincides with `rd_quad` leaves its bit set after the clear.
- R6: Slip pulses never cause `lock_evt` or `cur_lock_evt`.
- R7: Slip bits hold their value across any number of cycles in which `rd_quad` is low, so block reads do not disturb them.
- R8: `cur_status` bit 0 is the lock flag of the source at index `cur_sel` (R1 order) from the previous cycle. An index from 11 to 15 denotes the internal clock, which always reads as locked. Bits 15:8 carry the previous cycle's `rate_code`. All other bits are zero.
- R9: `cur_lock_evt` pulses together with `lock_evt` only when the lock input of the selected source changed. Changing `cur_sel` alone raises no event.
- R10: While reset is active and in the first cycle after it, with all inputs low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_in | input | 11 | Per-source lock level, synchronous to clk |
| slip_pulse | input | 11 | Per-source slip error pulse |
| rd_quad | input | 1 | Quadlet-read strobe of the extended status word |
| cur_sel | input | 4 | Index of the current clock source |
| rate_code | input | 8 | Nominal rate code of the current source |
| ext_status | output | 32 | Lock flags (10:0) and sticky slip flags (26:16) |
| cur_status | output | 32 | Current lock (0) and rate code (15:8) |
| lock_evt | output | 1 | Pulse on any lock flag change |
| cur_lock_evt | output | 1 | Pulse on a lock change of the selected source |

## Verification
Lock patterns are used that set the first and last sources together and then move a single middle source. These patterns separate correct bit ordering from reversed or shifted mappings, and they show whether an event arises from any lock change or only from some of them. Slip pulses are driven across long idle stretches, across a clearing read, and in the very cycle of a clearing read. This distinguishes sticky bits from live bits, distinguishes a clear that lands one cycle late from one that lands correctly, and exposes a clear that wins over a new error. The current-source word is driven with the selection moved between a locked source, an unlocked source and the internal index while lock changes are made on selected and unselected sources. This tells a selection-driven event apart from a real lock-driven one.

// File: rtl/cls_pkg.sv
package cls_pkg;
  localparam int SRC_CNT   = 11;
  localparam int LOCK_BASE = 0;
  localparam int SLIP_BASE = 16;
  localparam int RATE_BASE = 8;
  localparam int RATE_W    = 8;
  localparam int SEL_W     = 4;
  localparam int WORD_W    = 32;
endpackage

// File: rtl/cls_lock_stage.sv
module cls_lock_stage #(
  parameter int N = cls_pkg::SRC_CNT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lock_in,
  output logic [N-1:0] lock_q,
  output logic [N-1:0] lock_diff,
  output logic         any_evt
);
  // combinational difference between the live input and the held view
  assign lock_diff = lock_in ^ lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= '0;
      any_evt <= 1'b0;
    end else begin
      lock_q  <= lock_in;
      any_evt <= |lock_diff;
    end
  end
endmodule

// File: rtl/cls_slip_stage.sv
module cls_slip_stage #(
  parameter int N = cls_pkg::SRC_CNT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] slip_pulse,
  input  logic         clr,
  output logic [N-1:0] slip_q
);
  logic [N-1:0] kept;

  // a new error in the clearing cycle survives the clear
  assign kept = clr ? '0 : slip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slip_q <= '0;
    else        slip_q <= kept | slip_pulse;
  end
endmodule

// File: rtl/cls_cur_stage.sv
module cls_cur_stage #(
  parameter int N      = cls_pkg::SRC_CNT,
  parameter int SEL_W  = cls_pkg::SEL_W,
  parameter int RATE_W = cls_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cur_sel,
  input  logic [RATE_W-1:0] rate_code,
  input  logic [N-1:0]      lock_q,
  input  logic [N-1:0]      lock_diff,
  output logic              cur_locked,
  output logic [RATE_W-1:0] cur_rate,
  output logic              cur_evt
);
  localparam int SPAN = 1 << SEL_W;
  localparam int PAD  = SPAN - N;

  logic [SEL_W-1:0] sel_q;
  logic [SPAN-1:0]  lock_ext;
  logic [SPAN-1:0]  diff_ext;

  // indices past the external sources mean the internal clock: always locked, never changing
  generate
    if (PAD > 0) begin : g_pad
      assign lock_ext = {{PAD{1'b1}}, lock_q};
      assign diff_ext = {{PAD{1'b0}}, lock_diff};
    end else begin : g_nopad
      assign lock_ext = lock_q[SPAN-1:0];
      assign diff_ext = lock_diff[SPAN-1:0];
    end
  endgenerate

  assign cur_locked = lock_ext[sel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      cur_rate <= '0;
      cur_evt  <= 1'b0;
    end else begin
      sel_q    <= cur_sel;
      cur_rate <= rate_code;
      cur_evt  <= diff_ext[cur_sel];
    end
  end
endmodule

// File: rtl/clk_lock_slip_tracker.sv
module clk_lock_slip_tracker #(
  parameter int N_SRC     = cls_pkg::SRC_CNT,
  parameter int SEL_W     = cls_pkg::SEL_W,
  parameter int RATE_W    = cls_pkg::RATE_W,
  parameter int WORD_W    = cls_pkg::WORD_W,
  parameter int LOCK_BASE = cls_pkg::LOCK_BASE,
  parameter int SLIP_BASE = cls_pkg::SLIP_BASE,
  parameter int RATE_BASE = cls_pkg::RATE_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  lock_in,
  input  logic [N_SRC-1:0]  slip_pulse,
  input  logic              rd_quad,
  input  logic [SEL_W-1:0]  cur_sel,
  input  logic [RATE_W-1:0] rate_code,
  output logic [WORD_W-1:0] ext_status,
  output logic [WORD_W-1:0] cur_status,
  output logic              lock_evt,
  output logic              cur_lock_evt
);
  logic [N_SRC-1:0]  lock_q;
  logic [N_SRC-1:0]  lock_diff;
  logic [N_SRC-1:0]  slip_q;
  logic              cur_locked;
  logic [RATE_W-1:0] cur_rate;

  cls_lock_stage #(.N(N_SRC)) u_lock (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in),
    .lock_q(lock_q), .lock_diff(lock_diff), .any_evt(lock_evt)
  );

  cls_slip_stage #(.N(N_SRC)) u_slip (
    .clk(clk), .rst_n(rst_n), .slip_pulse(slip_pulse),
    .clr(rd_quad), .slip_q(slip_q)
  );

  cls_cur_stage #(.N(N_SRC), .SEL_W(SEL_W), .RATE_W(RATE_W)) u_cur (
    .clk(clk), .rst_n(rst_n), .cur_sel(cur_sel), .rate_code(rate_code),
    .lock_q(lock_q), .lock_diff(lock_diff),
    .cur_locked(cur_locked), .cur_rate(cur_rate), .cur_evt(cur_lock_evt)
  );

  always_comb begin
    ext_status = '0;
    ext_status[LOCK_BASE +: N_SRC] = lock_q;
    ext_status[SLIP_BASE +: N_SRC] = slip_q;
    cur_status = '0;
    cur_status[0] = cur_locked;
    cur_status[RATE_BASE +: RATE_W] = cur_rate;
  end
endmodule

// File: rtl/clk_lock_slip_tracker_chk.sv
module clk_lock_slip_tracker_chk #(
  parameter int N_SRC     = cls_pkg::SRC_CNT,
  parameter int SEL_W     = cls_pkg::SEL_W,
  parameter int RATE_W    = cls_pkg::RATE_W,
  parameter int WORD_W    = cls_pkg::WORD_W,
  parameter int LOCK_BASE = cls_pkg::LOCK_BASE,
  parameter int SLIP_BASE = cls_pkg::SLIP_BASE,
  parameter int RATE_BASE = cls_pkg::RATE_BASE
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  lock_in,
  input logic [N_SRC-1:0]  slip_pulse,
  input logic              rd_quad,
  input logic [SEL_W-1:0]  cur_sel,
  input logic [RATE_W-1:0] rate_code,
  input logic [WORD_W-1:0] ext_status,
  input logic [WORD_W-1:0] cur_status,
  input logic              lock_evt,
  input logic              cur_lock_evt
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R1
  lock_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ext_status[LOCK_BASE +: N_SRC] == $past(lock_in));

  // R2
  lock_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> lock_evt == (ext_status[LOCK_BASE +: N_SRC] != $past(ext_status[LOCK_BASE +: N_SRC])));

  // R3
  slip_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (ext_status[SLIP_BASE +: N_SRC] & $past(slip_pulse)) == $past(slip_pulse));

  // R4
  slip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rd_quad)) |-> ext_status[SLIP_BASE +: N_SRC] == $past(slip_pulse));

  // R7
  slip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(rd_quad)) |->
      (ext_status[SLIP_BASE +: N_SRC] & $past(ext_status[SLIP_BASE +: N_SRC]))
        == $past(ext_status[SLIP_BASE +: N_SRC]));

  // R9
  cur_evt_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lock_evt |-> lock_evt);

  // R8
  cur_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> cur_status[RATE_BASE +: RATE_W] == $past(rate_code));

  // R8
  cur_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(cur_sel) >= SEL_W'(N_SRC)) |-> cur_status[0]);
endmodule

bind clk_lock_slip_tracker clk_lock_slip_tracker_chk #(
  .N_SRC(N_SRC), .SEL_W(SEL_W), .RATE_W(RATE_W), .WORD_W(WORD_W),
  .LOCK_BASE(LOCK_BASE), .SLIP_BASE(SLIP_BASE), .RATE_BASE(RATE_BASE)
) u_chk (.*);

// File: tb/test_clk_lock_slip_tracker.sv
`timescale 1ns/1ps
module test_clk_lock_slip_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] lock_in = '0;
  logic [10:0] slip_pulse = '0;
  logic        rd_quad = 1'b0;
  logic [3:0]  cur_sel = '0;
  logic [7:0]  rate_code = '0;
  logic [31:0] ext_status, cur_status;
  logic        lock_evt, cur_lock_evt;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  clk_lock_slip_tracker i_clk_lock_slip_tracker (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .slip_pulse(slip_pulse),
    .rd_quad(rd_quad), .cur_sel(cur_sel), .rate_code(rate_code),
    .ext_status(ext_status), .cur_status(cur_status),
    .lock_evt(lock_evt), .cur_lock_evt(cur_lock_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 ext in reset", ext_status, 32'h0);
    chk("R10 cur in reset", cur_status, 32'h0);
    step();
    rst_n = 1'b1;
    step();
    chk("R10 ext after reset", ext_status, 32'h0);
    chk("R10 cur after reset", cur_status, 32'h0);
    chk("R10 evt after reset", {30'h0, lock_evt, cur_lock_evt}, 32'h0);
  endtask

  task automatic t_lock_map();
    lock_in = 11'h401;
    step();
    chk("R1 first/last source", ext_status, 32'h0000_0401);
    chk("R2 event on rise", {31'h0, lock_evt}, 32'h1);
    step();
    chk("R2 event one cycle", {31'h0, lock_evt}, 32'h0);
    lock_in = 11'h020;
    step();
    chk("R1 TDIF position", ext_status, 32'h0000_0020);
    chk("R2 event on mixed change", {31'h0, lock_evt}, 32'h1);
    step();
    chk("R2 no event when steady", {31'h0, lock_evt}, 32'h0);
  endtask

  task automatic t_slip_sticky();
    slip_pulse = 11'h010;
    step();
    slip_pulse = '0;
    chk("R3 ADAT slip bit", ext_status, 32'h0010_0020);
    chk("R6 slip no event", {30'h0, lock_evt, cur_lock_evt}, 32'h0);
    for (int i = 0; i < 5; i++) step();
    chk("R7 slip held without read", ext_status[26:16], 32'h010);
    slip_pulse = 11'h002;
    step();
    slip_pulse = '0;
    chk("R3 second slip accumulates", ext_status[26:16], 32'h012);
  endtask

  task automatic t_slip_clear();
    rd_quad = 1'b1;
    chk("R4 value visible in read cycle", ext_status[26:16], 32'h012);
    step();
    rd_quad = 1'b0;
    chk("R4 slips cleared", ext_status[26:16], 32'h0);
    chk("R4 lock untouched by read", ext_status[10:0], 32'h020);
  endtask

  task automatic t_slip_same_cycle();
    slip_pulse = 11'h009;
    step();
    rd_quad = 1'b1;
    slip_pulse = 11'h008;
    step();
    rd_quad = 1'b0;
    slip_pulse = '0;
    chk("R5 coincident slip kept", ext_status[26:16], 32'h008);
    step();
    chk("R5 kept bit persists", ext_status[26:16], 32'h008);
  endtask

  task automatic t_cur_status();
    cur_sel = 4'd5;
    rate_code = 8'h04;
    step();
    chk("R8 TDIF selected locked", cur_status, 32'h0000_0401);
    chk("R9 no event on select", {31'h0, cur_lock_evt}, 32'h0);
    cur_sel = 4'd0;
    step();
    chk("R8 AES1 selected unlocked", cur_status, 32'h0000_0400);
    chk("R9 no event on reselect", {31'h0, cur_lock_evt}, 32'h0);
    lock_in = 11'h021;
    step();
    chk("R9 selected change event", {30'h0, lock_evt, cur_lock_evt}, 32'h3);
    chk("R8 follows lock", cur_status[0], 32'h1);
    lock_in = 11'h421;
    step();
    chk("R9 unselected change", {30'h0, lock_evt, cur_lock_evt}, 32'h2);
    slip_pulse = 11'h001;
    step();
    slip_pulse = '0;
    chk("R6 slip on selected no event", {30'h0, lock_evt, cur_lock_evt}, 32'h0);
    cur_sel = 4'd12;
    rate_code = 8'h0a;
    lock_in = 11'h0;
    step();
    chk("R8 internal always locked", cur_status, 32'h0000_0a01);
    chk("R9 internal no cur event", {30'h0, lock_evt, cur_lock_evt}, 32'h2);
  endtask

  initial begin
    t_reset();
    t_lock_map();
    t_slip_sticky();
    t_slip_clear();
    t_slip_same_cycle();
    t_cur_status();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule